// File: doc/BRIEF.md
# Posted Write Buffer with Line Writeback

This block sits between the processor's store path and the system bus. It parks outgoing writes so that execution can continue while the bus carries them out. Two kinds of write come in. A single write is an uncached or write-through store and takes one 64-bit address/data pair. A line writeback is an evicted data-cache line and arrives as four pairs at once, filling every slot. Pending entries leave in arrival order through a valid/ready master port. A full flag lets the processor stall.

A lookup port compares a load address against every pending entry at 64-bit-word granularity. It returns the data of the youngest matching entry, so a load that follows a store to the same word gets the stored value in the same cycle. A repeated store to a word that is already pending takes a new slot and does not overwrite the older one. Both writes therefore reach the bus in program order.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty: `busValid` and `full` are 0, and `stWrReady` and `lineReady` are 1.
- R2: A single write is accepted (`stWrValid` and `stWrReady` both 1) on any cycle while fewer than four entries are pending. Writes can be accepted on consecutive cycles. `stWrReady` is 0 and `full` is 1 exactly when four entries are pending.
- R3: A line writeback is accepted only when the buffer is empty (`lineReady` = 1 exactly when nothing is pending). It creates four entries. Entry i has address `{lineAddr[31:5], i[1:0], 3'b000}` and data `lineData[64*i +: 64]`, and the entries drain in the order i = 0, 1, 2, 3. After it is accepted, `full` is 1.
- R4: When a line writeback and a single write are offered together on an empty buffer, the line writeback is accepted and `stWrReady` is 0 in that cycle.
- R5: Entries leave in arrival order, one per cycle in which `busValid` and `busReady` are both 1. `busValid` is 1 exactly when an entry is pending. `busAddr` and `busData` show the oldest entry and hold steady while `busReady` is 0.
- R6: `lookupHit` is 1 when any pending entry's address matches `lookupAddr` in bits 31:3. `lookupData` is then the data of the youngest such entry. Address bits 2:0 are ignored in the comparison.
- R7: A single write whose address matches a pending entry creates a new entry. The older entry is not modified, and both are later presented on the bus, oldest first.
- R8: A single write accepted in the same cycle as a bus handshake is stored. The entry count is unchanged, and the drain order stays correct.
- R9: An entry is visible to lookup from the cycle after it is accepted. The oldest entry stays visible until the cycle after its bus handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stWrValid | input | 1 | Single write offered |
| stWrAddr | input | 32 | Byte address of single write |
| stWrData | input | 64 | Data of single write |
| stWrReady | output | 1 | Single write can be accepted this cycle |
| lineValid | input | 1 | Line writeback offered |
| lineAddr | input | 32 | Line address (bits 4:0 ignored) |
| lineData | input | 256 | Four line words, word i at bits 64*i+63:64*i |
| lineReady | output | 1 | Line writeback can be accepted (buffer empty) |
| busValid | output | 1 | Oldest entry is presented to the bus |
| busAddr | output | 32 | Address of oldest entry |
| busData | output | 64 | Data of oldest entry |
| busReady | input | 1 | Bus takes the presented entry |
| lookupAddr | input | 32 | Load address to compare |
| lookupHit | output | 1 | A pending entry matches the load word |
| lookupData | output | 64 | Data of youngest matching entry |
| full | output | 1 | Four entries pending |

## Verification
Two events can fall in the same cycle: a single write entering the buffer and the oldest entry leaving on the bus. The random phase drives `busReady` and `stWrValid` independently with high probability, so many cycles carry both. A directed step sets up a partly filled buffer and fires both together. A reference queue is updated with the pop first and then the push. It is then compared each cycle with `busAddr`, `busData`, `full` and the lookup result, so an entry that is lost, duplicated or reordered shows up on a later handshake. Lookup is checked against the same queue in those cycles, which also judges whether an entry that is leaving stays visible.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // Control to datapath strobes, one cycle wide each.
  typedef struct packed {
    logic pushOne;   // store one single write at wrPtr
    logic pushLine;  // store a whole line in every slot
    logic pop;       // oldest entry taken by the bus
  } wbufStrobe_t;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stWrValid,
  input  logic                    lineValid,
  input  logic                    busReady,
  output logic                    stWrReady,
  output logic                    lineReady,
  output logic                    busValid,
  output logic                    full,
  output wbuf_pkg::wbufStrobe_t   strobe,
  output logic [PTR_W-1:0]        wrPtr,
  output logic [PTR_W-1:0]        rdPtr
);
  // DEPTH must be a power of two so that the pointers wrap naturally.
  logic [CNT_W-1:0] count;
  logic             empty;

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign lineReady = empty;
  assign busValid  = !empty;
  // A line writeback offered on an empty buffer wins over a single write.
  assign stWrReady = !full && !(lineValid && empty);

  always_comb begin
    strobe          = '0;
    strobe.pushLine = lineValid && empty;
    strobe.pushOne  = stWrValid && stWrReady;
    strobe.pop      = busValid && busReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.pushLine)
        count <= CNT_W'(DEPTH);
      else
        count <= count + CNT_W'(strobe.pushOne) - CNT_W'(strobe.pop);
      // A line fills every slot, so wrPtr comes back to where it started.
      if (strobe.pushOne) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)     rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_dp.sv
module wbuf_dp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int WORD_LSB = $clog2(DATA_W / 8),
  localparam int LINE_LSB = WORD_LSB + PTR_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wbuf_pkg::wbufStrobe_t     strobe,
  input  logic [PTR_W-1:0]          wrPtr,
  input  logic [PTR_W-1:0]          rdPtr,
  input  logic [ADDR_W-1:0]         stWrAddr,
  input  logic [DATA_W-1:0]         stWrData,
  input  logic [ADDR_W-1:0]         lineAddr,
  input  logic [DEPTH*DATA_W-1:0]   lineData,
  input  logic [ADDR_W-1:0]         lookupAddr,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busData,
  output logic                      lookupHit,
  output logic [DATA_W-1:0]         lookupData
);
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  slotVld;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [PTR_W-1:0] lineOfs;
    logic             hitOne;
    assign lineOfs = PTR_W'(e) - wrPtr;
    assign hitOne  = strobe.pushOne && (wrPtr == PTR_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN)
        slotVld[e] <= 1'b0;
      else if (hitOne || strobe.pushLine)
        slotVld[e] <= 1'b1;
      else if (strobe.pop && (rdPtr == PTR_W'(e)))
        slotVld[e] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (strobe.pushLine) begin
        addrMem[e] <= {lineAddr[ADDR_W-1:LINE_LSB], lineOfs, {WORD_LSB{1'b0}}};
        dataMem[e] <= lineData[lineOfs*DATA_W +: DATA_W];
      end else if (hitOne) begin
        addrMem[e] <= stWrAddr;
        dataMem[e] <= stWrData;
      end
    end
  end

  assign busAddr = addrMem[rdPtr];
  assign busData = dataMem[rdPtr];

  // Walk from oldest to youngest; the last match seen is the youngest one.
  logic [PTR_W-1:0] scanIdx;
  always_comb begin
    lookupHit  = 1'b0;
    lookupData = '0;
    scanIdx    = rdPtr;
    for (int i = 0; i < DEPTH; i++) begin
      scanIdx = rdPtr + PTR_W'(i);
      if (slotVld[scanIdx] &&
          addrMem[scanIdx][ADDR_W-1:WORD_LSB] == lookupAddr[ADDR_W-1:WORD_LSB]) begin
        lookupHit  = 1'b1;
        lookupData = dataMem[scanIdx];
      end
    end
  end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stWrValid,
  input  logic [ADDR_W-1:0]       stWrAddr,
  input  logic [DATA_W-1:0]       stWrData,
  output logic                    stWrReady,
  input  logic                    lineValid,
  input  logic [ADDR_W-1:0]       lineAddr,
  input  logic [DEPTH*DATA_W-1:0] lineData,
  output logic                    lineReady,
  output logic                    busValid,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busData,
  input  logic                    busReady,
  input  logic [ADDR_W-1:0]       lookupAddr,
  output logic                    lookupHit,
  output logic [DATA_W-1:0]       lookupData,
  output logic                    full
);
  wbuf_pkg::wbufStrobe_t strobe;
  logic [PTR_W-1:0]      wrPtr;
  logic [PTR_W-1:0]      rdPtr;

  wbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .stWrValid(stWrValid), .lineValid(lineValid), .busReady(busReady),
    .stWrReady(stWrReady), .lineReady(lineReady), .busValid(busValid),
    .full(full), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  wbuf_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .stWrAddr(stWrAddr), .stWrData(stWrData),
    .lineAddr(lineAddr), .lineData(lineData), .lookupAddr(lookupAddr),
    .busAddr(busAddr), .busData(busData),
    .lookupHit(lookupHit), .lookupData(lookupData)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              stWrValid,
  input logic              stWrReady,
  input logic              lineValid,
  input logic              lineReady,
  input logic              busValid,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              full
);
  // R2: no single write is taken while four entries are pending
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stWrReady);

  // R3: a line is taken only when nothing is pending
  a_r3_line_on_empty: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && lineReady) |-> !busValid);

  // R3: an accepted line leaves the buffer full
  a_r3_line_fills: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && lineReady) |=> (full && busValid));

  // R4: a line and a single write are never taken in the same cycle
  a_r4_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && lineReady) |-> !(stWrValid && stWrReady));

  // R5: a stalled bus offer holds its entry
  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busData)));
endmodule

bind wbuf_top wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .stWrValid(stWrValid), .stWrReady(stWrReady),
  .lineValid(lineValid), .lineReady(lineReady), .busValid(busValid),
  .busReady(busReady), .busAddr(busAddr), .busData(busData), .full(full)
);

// File: tb/wbuf_top_tb_top.sv
module wbuf_top_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         stWrValid;
  logic [31:0]  stWrAddr;
  logic [63:0]  stWrData;
  logic         stWrReady;
  logic         lineValid;
  logic [31:0]  lineAddr;
  logic [255:0] lineData;
  logic         lineReady;
  logic         busValid;
  logic [31:0]  busAddr;
  logic [63:0]  busData;
  logic         busReady;
  logic [31:0]  lookupAddr;
  logic         lookupHit;
  logic [63:0]  lookupData;
  logic         full;

  always #5 clk = ~clk;

  wbuf_top dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference queue
  logic [31:0] qAddr[$];
  logic [63:0] qData[$];

  // inputs for the next cycle, applied at the falling edge
  logic         nSv = 0, nLv = 0, nBr = 0;
  logic [31:0]  nSa = 0, nLa = 0, nLk = 0;
  logic [63:0]  nSd = 0;
  logic [255:0] nLd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit refHit(input logic [31:0] a);
    refHit = 0;
    foreach (qAddr[i]) if (qAddr[i][31:3] == a[31:3]) refHit = 1;
  endfunction

  function automatic logic [63:0] refData(input logic [31:0] a);
    refData = '0;
    foreach (qAddr[i]) if (qAddr[i][31:3] == a[31:3]) refData = qData[i];
  endfunction

  task automatic tick();
    bit expSr, expLr, stAcc, lnAcc, popAcc, eh;
    @(negedge clk);
    stWrValid = nSv; stWrAddr = nSa; stWrData = nSd;
    lineValid = nLv; lineAddr = nLa; lineData = nLd;
    busReady = nBr; lookupAddr = nLk;
    #1;
    expLr = (qAddr.size() == 0);
    expSr = (qAddr.size() < 4) && !(nLv && expLr);
    chk(stWrReady == expSr, "R2 R4", "stWrReady", 64'(stWrReady), 64'(expSr));
    chk(lineReady == expLr, "R3", "lineReady", 64'(lineReady), 64'(expLr));
    chk(full == (qAddr.size() == 4), "R2 R3", "full", 64'(full), 64'(qAddr.size() == 4));
    chk(busValid == (qAddr.size() != 0), "R5", "busValid", 64'(busValid), 64'(qAddr.size() != 0));
    if (qAddr.size() != 0) begin
      chk(busAddr == qAddr[0], "R5", "busAddr", 64'(busAddr), 64'(qAddr[0]));
      chk(busData == qData[0], "R5", "busData", busData, qData[0]);
    end
    eh = refHit(nLk);
    chk(lookupHit == eh, "R6 R9", "lookupHit", 64'(lookupHit), 64'(eh));
    if (eh) chk(lookupData == refData(nLk), "R6 R9", "lookupData", lookupData, refData(nLk));
    lnAcc  = nLv && expLr;
    stAcc  = nSv && expSr;
    popAcc = nBr && (qAddr.size() != 0);
    @(posedge clk);
    if (popAcc) begin void'(qAddr.pop_front()); void'(qData.pop_front()); end
    if (lnAcc)
      for (int i = 0; i < 4; i++) begin
        qAddr.push_back({nLa[31:5], 2'(i), 3'b000});
        qData.push_back(nLd[64*i +: 64]);
      end
    if (stAcc) begin qAddr.push_back(nSa); qData.push_back(nSd); end
  endtask

  task automatic idle();
    nSv = 0; nLv = 0; nBr = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 0;
    stWrValid = 0; stWrAddr = 0; stWrData = 0; lineValid = 0; lineAddr = 0;
    lineData = 0; busReady = 0; lookupAddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset state
    chk(busValid == 0 && full == 0, "R1", "busValid/full", {busValid, full}, 0);
    chk(stWrReady && lineReady, "R1", "ready pair", {stWrReady, lineReady}, 2'b11);

    // R2: four back-to-back stores with the bus stalled, then a fifth is held
    idle();
    for (int i = 0; i < 4; i++) begin
      nSv = 1; nSa = 32'h2000 + 32'(i*8); nSd = 64'hA000 + 64'(i); nLk = 32'h2008;
      tick();
    end
    nSa = 32'h2100; nSd = 64'hBAD; tick();
    #1 chk(full && !stWrReady, "R2", "fifth store held", {full, stWrReady}, 2'b10);
    // R3: line offered while entries pending is stalled; R5 drain frees it
    nSv = 0; nLv = 1; nLa = 32'h4020;
    for (int i = 0; i < 4; i++) nLd[64*i +: 64] = 64'hC000 + 64'(i);
    nBr = 0; tick(); tick();
    nBr = 1; repeat (4) tick();
    nBr = 0; tick();               // line accepted here
    nLv = 0; nLk = 32'h4037; tick();
    #1 chk(full && busAddr == 32'h4020, "R3", "line head", 64'(busAddr), 64'h4020);
    nBr = 1; repeat (4) tick();
    // R4: line and store together on empty buffer
    nSv = 1; nSa = 32'h3000; nSd = 64'h1; nLv = 1; nLa = 32'h5000; nBr = 0;
    tick();
    nSv = 0; nLv = 0; nBr = 1; repeat (4) tick();
    // R7: duplicate address makes two entries, youngest for lookup
    nBr = 0; nSv = 1; nSa = 32'h6000; nSd = 64'h11; tick();
    nSd = 64'h22; nSa = 32'h6004; tick();
    nSv = 0; nLk = 32'h6001; tick();
    #1 chk(lookupData == 64'h22, "R7", "youngest dup", lookupData, 64'h22);
    chk(busData == 64'h11, "R7", "older dup first", busData, 64'h11);
    nBr = 1; tick();
    #1 chk(busData == 64'h22, "R7", "second dup", busData, 64'h22);
    // R8: push and pop in the same cycle
    nBr = 0; nSv = 1; nSa = 32'h7000; nSd = 64'h77; tick();
    nBr = 1; nSa = 32'h7008; nSd = 64'h78; tick();
    nSv = 0; nBr = 0; tick();
    #1 chk(busAddr == 32'h7000 && !full, "R8", "order after push+pop", 64'(busAddr), 64'h7000);
    nBr = 1; repeat (4) tick();

    // random phase
    for (int c = 0; c < 3000; c++) begin
      nSv = ($urandom % 4) != 0;
      nSa = 32'h8000 + 32'(($urandom % 8) * 8) + 32'($urandom % 8);
      nSd = {$urandom, $urandom};
      nLv = ($urandom % 8) == 0;
      nLa = 32'h8000 + 32'(($urandom % 2) * 32);
      for (int i = 0; i < 8; i++) nLd[32*i +: 32] = $urandom;
      nBr = ($urandom % 3) != 0;
      nLk = 32'h8000 + 32'(($urandom % 10) * 8) + 32'($urandom % 8);
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule